// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block collects eight interrupt request lines into a request register and reduces them to a single pending request with a line number. Each line can be set to edge or level capture. An 8-bit mask hides chosen lines. An in-service register records which requests are being handled. The winner is found by a priority scan whose starting line can be moved by a programmable rotation offset. A request reaches the output only when it strictly outranks the best line already in service.

The surrounding logic does the following:
- loads the mask, trigger-mode and rotation registers through write strobes;
- pulses set and clear commands on the in-service register when a request is taken or finished;
- reads a registered pending flag and a 3-bit line number.

On a unit used as the master of a cascade, an option makes the scan ignore the in-service bit of the cascade line. A second request through that line can then reach the output while an earlier one is still in service. Bus decoding and vector formation are left to other blocks.

Top module: `irq_resolver`

## Requirements
- R1: A synchronous reset clears the request, edge-history, mask, in-service and rotation registers and the outputs. It leaves the trigger-mode register as last written, and a trigger-mode write is accepted even while reset is high.
- R2: A line whose trigger-mode bit is 1 (level) copies its input into its request bit at every clock edge, so dropping the input withdraws the request.
- R3: A line whose trigger-mode bit is 0 (edge) sets its request bit only when the input is high and the stored previous level is low. A low input does not clear the request, and an input held high does not set it again.
- R4: Only lines whose mask bit is 0 take part. Mask bit 1 hides the line, and a fully masked request register gives no pending output.
- R5: Scan position p stands for line (p + offset) mod 8, and a lower position wins. With offset 0, line 0 has the highest priority.
- R6: The pending flag rises only when the winner's position is strictly lower than the position of the best in-service line. An equal or worse position gives no pending output.
- R7: The request register updates at the first clock edge after an input change. The pending flag and line number are registered from it at the next edge, and the line number is 0 whenever the flag is low.
- R8: An in-service set pulse for line k sets in-service bit k. At the same edge it clears request bit k if line k is in edge mode; a level-mode request is kept.
- R9: An in-service clear pulse for line k clears in-service bit k. If set and clear name the same line in the same cycle, the set wins.
- R10: When the unit is built as a master and the nesting option input is high, in-service bit 2 (the cascade line) is left out of the in-service priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Raw request lines |
| mask_wr | input | 1 | Load the mask register |
| mask_wdata | input | 8 | Mask value, 1 hides a line |
| trig_wr | input | 1 | Load the trigger-mode register |
| trig_wdata | input | 8 | Trigger modes, 1 level, 0 edge |
| rot_wr | input | 1 | Load the rotation offset |
| rot_wdata | input | 3 | Rotation offset |
| svc_set | input | 1 | Set an in-service bit |
| svc_set_line | input | 3 | Line to set in service |
| svc_clr | input | 1 | Clear an in-service bit |
| svc_clr_line | input | 3 | Line to clear from service |
| nest_en | input | 1 | Ignore the cascade line's in-service bit (master only) |
| irq_pend | output | 1 | Registered pending request flag |
| irq_line | output | 3 | Registered winning line number |

## Verification
A request bit that is latched or cleared wrongly shows on irq_pend two edges after the input change: the flag stays low, or a lower-ranked line number appears. A corrupted in-service bit or rotation offset shows at the next registered output as a request that is wrongly blocked or a wrong line number. The bench drives only the ports. It exposes hidden state through the outputs, for example by releasing the in-service bit after an acknowledge to show whether an edge request was cleared, or whether a level request was kept.

// File: rtl/irq_resolver_pkg.sv
package irq_resolver_pkg;
  // trigger-mode encoding, one bit per line
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  // decoded one-hot select of a line number
  function automatic logic [7:0] line_onehot8(input logic [2:0] line);
    logic [7:0] v;
    v = '0;
    v[line] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] trig_q,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] irr_q,
  output logic [N-1:0] hist_q
);
  import irq_resolver_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        irr_q[i]  <= 1'b0;
        hist_q[i] <= 1'b0;
      end else if (trig_q[i] == TRIG_LEVEL) begin
        irr_q[i]  <= req_in[i];
        hist_q[i] <= req_in[i];
      end else begin
        // acknowledge drops the bit, a fresh rising edge sets it again
        irr_q[i]  <= (irr_q[i] & ~ack_clr[i]) | (req_in[i] & ~hist_q[i]);
        hist_q[i] <= req_in[i];
      end
    end
  end
endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
  parameter int N   = 8,
  parameter int IDW = $clog2(N)
) (
  input  logic [N-1:0]   vec,
  input  logic [IDW-1:0] off,
  output logic [IDW:0]   prio
);
  logic [N-1:0] rot;

  // position p looks at line (p + off) mod N; N is a power of two
  for (genvar p = 0; p < N; p++) begin : g_rot
    localparam logic [IDW-1:0] PIDX = IDW'(p);
    logic [IDW-1:0] src;
    assign src    = PIDX + off;
    assign rot[p] = vec[src];
  end

  always_comb begin
    prio = (IDW+1)'(N);
    for (int p = N - 1; p >= 0; p--) begin
      if (rot[p]) prio = (IDW+1)'(p);
    end
  end
endmodule

// File: rtl/irq_svc_reg.sv
module irq_svc_reg #(
  parameter int N   = 8,
  parameter int IDW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           set_en,
  input  logic [IDW-1:0] set_line,
  input  logic           clr_en,
  input  logic [IDW-1:0] clr_line,
  output logic [N-1:0]   isr_q
);
  logic [N-1:0] set_v, clr_v;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    if (set_en) set_v[set_line] = 1'b1;
    if (clr_en) clr_v[clr_line] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) isr_q <= '0;
    else     isr_q <= (isr_q & ~clr_v) | set_v;
  end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int N            = 8,
  parameter int IDW          = $clog2(N),
  parameter bit IS_MASTER    = 1'b1,
  parameter int CASCADE_LINE = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   req_in,
  input  logic           mask_wr,
  input  logic [N-1:0]   mask_wdata,
  input  logic           trig_wr,
  input  logic [N-1:0]   trig_wdata,
  input  logic           rot_wr,
  input  logic [IDW-1:0] rot_wdata,
  input  logic           svc_set,
  input  logic [IDW-1:0] svc_set_line,
  input  logic           svc_clr,
  input  logic [IDW-1:0] svc_clr_line,
  input  logic           nest_en,
  output logic           irq_pend,
  output logic [IDW-1:0] irq_line
);
  logic [N-1:0]   mask_q, trig_q, irr_q, hist_q, isr_q;
  logic [N-1:0]   ack_v, cand, svc_eff;
  logic [IDW-1:0] rot_q, win_line;
  logic [IDW:0]   cand_prio, svc_prio;
  logic           pend_next;

  // configuration; trigger modes survive reset
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      rot_q  <= '0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      if (rot_wr)  rot_q  <= rot_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (trig_wr) trig_q <= trig_wdata;
  end

  always_comb begin
    ack_v = '0;
    if (svc_set) ack_v[svc_set_line] = 1'b1;
  end

  irq_req_latch #(.N(N)) u_latch (
    .clk(clk), .rst(rst), .req_in(req_in), .trig_q(trig_q),
    .ack_clr(ack_v), .irr_q(irr_q), .hist_q(hist_q)
  );

  irq_svc_reg #(.N(N), .IDW(IDW)) u_svc (
    .clk(clk), .rst(rst),
    .set_en(svc_set), .set_line(svc_set_line),
    .clr_en(svc_clr), .clr_line(svc_clr_line),
    .isr_q(isr_q)
  );

  assign cand = irr_q & ~mask_q;

  if (IS_MASTER) begin : g_master
    logic [N-1:0] skip_v;
    always_comb begin
      skip_v = '0;
      skip_v[CASCADE_LINE] = nest_en;
    end
    assign svc_eff = isr_q & ~skip_v;
  end else begin : g_slave
    assign svc_eff = isr_q;
  end

  irq_prio_scan #(.N(N), .IDW(IDW)) u_scan_req (
    .vec(cand), .off(rot_q), .prio(cand_prio)
  );

  irq_prio_scan #(.N(N), .IDW(IDW)) u_scan_svc (
    .vec(svc_eff), .off(rot_q), .prio(svc_prio)
  );

  assign win_line  = cand_prio[IDW-1:0] + rot_q;
  assign pend_next = cand_prio < svc_prio;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pend <= 1'b0;
      irq_line <= '0;
    end else begin
      irq_pend <= pend_next;
      irq_line <= pend_next ? win_line : '0;
    end
  end
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
  parameter int N            = 8,
  parameter int IDW          = $clog2(N),
  parameter bit IS_MASTER    = 1'b1,
  parameter int CASCADE_LINE = 2
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   req_in,
  input logic           svc_set,
  input logic [IDW-1:0] svc_set_line,
  input logic           svc_clr,
  input logic [IDW-1:0] svc_clr_line,
  input logic           nest_en,
  input logic           irq_pend,
  input logic [IDW-1:0] irq_line,
  input logic [N-1:0]   irr_q,
  input logic [N-1:0]   hist_q,
  input logic [N-1:0]   mask_q,
  input logic [N-1:0]   isr_q,
  input logic [N-1:0]   trig_q
);
  logic [N-1:0] irr_d, mask_d, isr_d;
  logic         nest_d;

  always_ff @(posedge clk) begin
    irr_d  <= irr_q;
    mask_d <= mask_q;
    isr_d  <= isr_q;
    nest_d <= nest_en;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!irq_pend && irq_line == '0 && irr_q == '0 && isr_q == '0));

  for (genvar i = 0; i < N; i++) begin : g_bit
    assert_level_follow_R2: assert property (@(posedge clk) disable iff (rst)
      ($past(trig_q[i]) && !$past(rst)) |-> (irr_q[i] == $past(req_in[i])));
    assert_edge_capture_R3: assert property (@(posedge clk) disable iff (rst)
      (!$past(trig_q[i]) && !$past(rst) && $past(req_in[i]) && !$past(hist_q[i]))
      |-> irr_q[i]);
  end

  assert_pend_unmasked_R4: assert property (@(posedge clk) disable iff (rst)
    irq_pend |-> (irr_d[irq_line] && !mask_d[irq_line]));

  assert_not_in_service_R6: assert property (@(posedge clk) disable iff (rst)
    irq_pend |-> (!isr_d[irq_line] ||
                  (IS_MASTER && nest_d && irq_line == IDW'(CASCADE_LINE))));

  assert_idle_line_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !irq_pend |-> (irq_line == '0));

  assert_svc_set_R8: assert property (@(posedge clk) disable iff (rst)
    svc_set |=> isr_q[$past(svc_set_line)]);

  assert_svc_clr_R9: assert property (@(posedge clk) disable iff (rst)
    (svc_clr && !(svc_set && svc_set_line == svc_clr_line))
    |=> !isr_q[$past(svc_clr_line)]);
endmodule

bind irq_resolver irq_resolver_chk #(
  .N(N), .IDW(IDW), .IS_MASTER(IS_MASTER), .CASCADE_LINE(CASCADE_LINE)
) u_chk (
  .clk(clk), .rst(rst), .req_in(req_in),
  .svc_set(svc_set), .svc_set_line(svc_set_line),
  .svc_clr(svc_clr), .svc_clr_line(svc_clr_line),
  .nest_en(nest_en), .irq_pend(irq_pend), .irq_line(irq_line),
  .irr_q(irr_q), .hist_q(hist_q), .mask_q(mask_q),
  .isr_q(isr_q), .trig_q(trig_q)
);

// File: tb/sim_irq_resolver.sv
module sim_irq_resolver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req_in = '0;
  logic       mask_wr = 1'b0, trig_wr = 1'b0, rot_wr = 1'b0;
  logic [7:0] mask_wdata = '0, trig_wdata = '0;
  logic [2:0] rot_wdata = '0;
  logic       svc_set = 1'b0, svc_clr = 1'b0, nest_en = 1'b0;
  logic [2:0] svc_set_line = '0, svc_clr_line = '0;
  logic       irq_pend;
  logic [2:0] irq_line;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_resolver u0 (
    .clk(clk), .rst(rst), .req_in(req_in),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .trig_wr(trig_wr), .trig_wdata(trig_wdata),
    .rot_wr(rot_wr), .rot_wdata(rot_wdata),
    .svc_set(svc_set), .svc_set_line(svc_set_line),
    .svc_clr(svc_clr), .svc_clr_line(svc_clr_line),
    .nest_en(nest_en), .irq_pend(irq_pend), .irq_line(irq_line)
  );

  // {req, mask, rot, in-service, expected pend, expected line}, all lines level
  localparam logic [30:0] VEC [12] = '{
    {8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 3'd0},
    {8'h01, 8'h00, 3'd0, 8'h00, 1'b1, 3'd0},
    {8'h90, 8'h00, 3'd0, 8'h00, 1'b1, 3'd4},
    {8'h90, 8'h10, 3'd0, 8'h00, 1'b1, 3'd7},
    {8'h90, 8'h00, 3'd5, 8'h00, 1'b1, 3'd7},
    {8'h03, 8'h00, 3'd1, 8'h00, 1'b1, 3'd1},
    {8'h08, 8'h00, 3'd0, 8'h04, 1'b0, 3'd0},
    {8'h02, 8'h00, 3'd0, 8'h04, 1'b1, 3'd1},
    {8'h04, 8'h00, 3'd0, 8'h04, 1'b0, 3'd0},
    {8'h01, 8'h00, 3'd3, 8'h10, 1'b0, 3'd0},
    {8'h40, 8'h00, 3'd3, 8'h01, 1'b1, 3'd6},
    {8'hFF, 8'hFF, 3'd0, 8'h00, 1'b0, 3'd0}
  };

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input logic [3:0] exp);
    checks++;
    if ({irq_pend, irq_line} !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, {irq_pend, irq_line}, exp);
    end
  endtask

  task automatic do_reset(input logic wr_trig, input logic [7:0] trig);
    rst = 1'b1; trig_wr = wr_trig; trig_wdata = trig;
    tick();
    rst = 1'b0; trig_wr = 1'b0;
    tick();
  endtask

  task automatic pulse_set(input logic [2:0] l);
    svc_set = 1'b1; svc_set_line = l; tick(); svc_set = 1'b0;
  endtask

  task automatic pulse_clr(input logic [2:0] l);
    svc_clr = 1'b1; svc_clr_line = l; tick(); svc_clr = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // table walk: resolution, masking, rotation, strict in-service compare
    for (int v = 0; v < 12; v++) begin
      req_in = '0;
      do_reset(1'b1, 8'hFF);
      mask_wr = 1'b1; mask_wdata = VEC[v][22:15];
      rot_wr  = 1'b1; rot_wdata  = VEC[v][14:12];
      tick();
      mask_wr = 1'b0; rot_wr = 1'b0;
      for (int b = 0; b < 8; b++) if (VEC[v][4+b]) pulse_set(3'(b));
      req_in = VEC[v][30:23];
      tick(3);
      chk($sformatf("R4 R5 R6 vector %0d", v), VEC[v][3:0]);
    end

    // R1: line0 level, others edge; dirty state then reset without trig write
    do_reset(1'b1, 8'h01);
    mask_wr = 1'b1; mask_wdata = 8'hF0; rot_wr = 1'b1; rot_wdata = 3'd3; tick();
    mask_wr = 1'b0; rot_wr = 1'b0;
    pulse_set(3'd6);
    req_in = 8'h01; tick(2);
    req_in = 8'h00;
    do_reset(1'b0, 8'h00);
    chk("R1 outputs after reset", 4'h0);
    req_in = 8'h08; tick(3);
    chk("R1 R3 mask cleared, edge line3", {1'b1, 3'd3});
    req_in = 8'h09; tick(3);
    chk("R1 R5 rotation cleared, line0 wins", {1'b1, 3'd0});
    req_in = 8'h08; tick(3);
    chk("R1 R2 trigger kept, level line0 withdrawn", {1'b1, 3'd3});
    req_in = 8'h00; tick(3);
    chk("R3 edge request survives low input", {1'b1, 3'd3});
    pulse_set(3'd3); tick(2);
    chk("R8 in service blocks line3", 4'h0);
    pulse_clr(3'd3); tick(2);
    chk("R8 edge request cleared by acknowledge", 4'h0);
    req_in = 8'h08; tick(3);
    chk("R3 new rising edge", {1'b1, 3'd3});
    pulse_set(3'd3); pulse_clr(3'd3); tick(3);
    chk("R3 held high does not retrigger", 4'h0);

    // R7 latency on edge line5 (line3 held high without new edge)
    req_in = 8'h28; tick();
    chk("R7 no output one edge after input", 4'h0);
    tick();
    chk("R7 output two edges after input", {1'b1, 3'd5});

    // R9 same-cycle set and clear on level line0
    req_in = 8'h29; tick(3);
    chk("R2 level line0 wins", {1'b1, 3'd0});
    svc_set = 1'b1; svc_set_line = 3'd0;
    svc_clr = 1'b1; svc_clr_line = 3'd0;
    tick();
    svc_set = 1'b0; svc_clr = 1'b0;
    tick(2);
    chk("R9 set wins over clear, line5 edge also blocked", 4'h0);
    pulse_clr(3'd0); tick(2);
    chk("R8 level request kept after acknowledge", {1'b1, 3'd0});

    // R10 cascade nesting option
    req_in = 8'h00;
    do_reset(1'b1, 8'hFF);
    req_in = 8'h04;
    pulse_set(3'd2); tick(2);
    chk("R10 cascade blocked without option", 4'h0);
    nest_en = 1'b1; tick(2);
    chk("R10 cascade passes with option", {1'b1, 3'd2});
    nest_en = 1'b0; tick(2);
    chk("R10 option released blocks again", 4'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule